// File: doc/BRIEF.md
# TDM Multi-Channel Audio Deserializer

This block takes eight channels of time-division-multiplexed audio and presents them as eight parallel 24-bit two's-complement samples. It runs directly on the bit clock. A frame-sync input marks where each frame begins.

A mode input selects one of two framings. In octal framing, one frame lasts 256 bit clocks and all eight 32-bit slots arrive on data line 0. In dual framing, one frame lasts 128 bit clocks, and two data lines each carry four slots. Every slot holds its sample MSB first in its first 24 bits; the remaining 8 bits are padding.

When a frame completes, all eight outputs update in the same cycle, together with a one-cycle valid strobe. If a frame sync arrives before a frame is complete, the partial frame is discarded, a one-cycle error strobe is raised, and capture starts again from the new sync.

Top module: `tdm_deser`

## Requirements
- R1: While rst_ni is low, samples_o is all zero, and frame_valid_o and frame_err_o are 0.
- R2: A frame starts at the rising bit-clock edge where fsync_i is sampled 1 after being sampled 0 at the previous edge. The bit sampled at that edge is the MSB of slot 0. Holding fsync_i high for longer does not start another frame.
- R3: With dual_mode_i = 0, a frame is 256 bit clocks long. Slot k (bits 32k to 32k+31 of the frame) on sdata_i[0] goes to channel k, for k = 0..7. sdata_i[1] is ignored.
- R4: With dual_mode_i = 1, a frame is 128 bit clocks long. Slot k on sdata_i[0] goes to channel k, and slot k on sdata_i[1] goes to channel 4+k, for k = 0..3.
- R5: Within a slot, bits 0..23 form the sample, MSB first. Bits 24..31 are ignored.
- R6: Channel k appears on samples_o[24k+23:24k]. All channels update together in the cycle after the edge that samples the last bit of a frame, and frame_valid_o is 1 for exactly that cycle. Outside that update, samples_o holds its value.
- R7: A frame start that arrives while a frame is still incomplete (including at its last bit) raises frame_err_o for the one cycle after that edge. The partial frame produces no valid strobe and leaves samples_o unchanged, and the new edge becomes slot 0 of a new frame.
- R8: When no frame start occurs, no data is captured and frame_valid_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; data and sync are sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dual_mode_i | input | 1 | 0: octal framing (256 clocks, one line); 1: dual framing (128 clocks, two lines) |
| fsync_i | input | 1 | Frame sync; its rising edge marks slot 0, bit 0 |
| sdata_i | input | 2 | Serial data lines 0 and 1 |
| samples_o | output | 192 | Eight 24-bit samples; channel k at bits 24k+23:24k |
| frame_valid_o | output | 1 | One-cycle strobe when samples_o updates |
| frame_err_o | output | 1 | One-cycle strobe when a frame is cut short by a new sync |

## Verification
The sample update and the valid strobe are both due in the cycle after the rising edge that samples bit 127 or bit 255 of the frame. The error strobe is due in the cycle after the edge that sees the early sync. Because of this, the bench drives each bit on the falling edge, waits for the rising edge that takes the last bit, and checks the outputs 1 ns later, then checks one cycle later that the strobe has dropped. Error and held-sample checks are taken at the falling edge that follows the new sync. A valid-strobe count is kept at every falling edge and compared against the number of complete frames sent, so that no strobe from an aborted frame or an idle period goes unnoticed.

// File: rtl/tdm_deser_pkg.sv
package tdm_deser_pkg;
  typedef enum logic {
    FRAME_OCTAL = 1'b0,
    FRAME_DUAL  = 1'b1
  } frame_mode_e;

  // dual framing: first half of channels on line 0, second half on line 1
  function automatic int unsigned dual_line(int unsigned ch, int unsigned per_line);
    return ch / per_line;
  endfunction

  function automatic int unsigned dual_slot(int unsigned ch, int unsigned per_line);
    return ch % per_line;
  endfunction
endpackage

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
  import tdm_deser_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  localparam int unsigned CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  frame_mode_e      mode_i,
  input  logic             fsync_i,
  output logic             cap_en_o,
  output logic [CNT_W-1:0] bit_idx_o,
  output logic             done_o,
  output logic             err_o
);
  logic             fs_q;
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start;
  logic [CNT_W-1:0] last_idx;

  assign start     = fsync_i & ~fs_q;
  assign last_idx  = (mode_i == FRAME_DUAL) ? CNT_W'(FRAME_BITS/2 - 1) : CNT_W'(FRAME_BITS - 1);
  assign bit_idx_o = start ? '0 : cnt_q;
  assign cap_en_o  = start | active_q;
  assign done_o    = cap_en_o && (bit_idx_o == last_idx);
  assign err_o     = start & active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q     <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      fs_q <= fsync_i;
      if (start) begin
        active_q <= 1'b1;
        cnt_q    <= CNT_W'(1);
      end else if (active_q) begin
        if (done_o) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assert_cnt_in_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q <= last_idx));
  assert_err_no_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !done_o);
  assert_idle_no_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !start) |-> !done_o);
  assert_restart_slot0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (active_q && cnt_q == CNT_W'(1)));
endmodule

// File: rtl/tdm_slot_capture.sv
module tdm_slot_capture
  import tdm_deser_pkg::*;
#(
  parameter int unsigned NUM_CH    = 8,
  parameter int unsigned SAMPLE_W  = 24,
  parameter int unsigned SLOT_W    = 32,
  parameter int unsigned NUM_LINES = 2,
  localparam int unsigned FRAME_BITS = NUM_CH * SLOT_W,
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS),
  localparam int unsigned POS_W      = $clog2(SLOT_W),
  localparam int unsigned SIDX_W     = CNT_W - POS_W,
  localparam int unsigned PER_LINE   = NUM_CH / NUM_LINES
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  frame_mode_e                mode_i,
  input  logic                       cap_en_i,
  input  logic [CNT_W-1:0]           bit_idx_i,
  input  logic [NUM_LINES-1:0]       sdata_i,
  output logic [NUM_CH*SAMPLE_W-1:0] shift_o
);
  logic [POS_W-1:0]  pos;
  logic [SIDX_W-1:0] slot_now;
  logic              in_sample;

  assign pos       = bit_idx_i[POS_W-1:0];
  assign slot_now  = bit_idx_i[CNT_W-1:POS_W];
  assign in_sample = ({1'b0, pos} < (POS_W+1)'(SAMPLE_W));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int unsigned D_LINE = dual_line(ch, PER_LINE);
    localparam int unsigned D_SLOT = dual_slot(ch, PER_LINE);
    logic [SAMPLE_W-1:0] sh_q;
    logic [SIDX_W-1:0]   my_slot;
    logic                my_bit;
    logic                hit;

    assign my_slot = (mode_i == FRAME_DUAL) ? SIDX_W'(D_SLOT) : SIDX_W'(ch);
    assign my_bit  = (mode_i == FRAME_DUAL) ? sdata_i[D_LINE] : sdata_i[0];
    assign hit     = cap_en_i && in_sample && (slot_now == my_slot);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  sh_q <= '0;
      else if (hit) sh_q <= {sh_q[SAMPLE_W-2:0], my_bit};
    end

    assign shift_o[ch*SAMPLE_W +: SAMPLE_W] = sh_q;
  end

  assert_pad_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && !in_sample) |=> $stable(shift_o));
  assert_no_capture_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> $stable(shift_o));
endmodule

// File: rtl/tdm_out_reg.sv
module tdm_out_reg #(
  parameter int unsigned WIDTH = 192
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             err_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o,
  output logic             err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= load_i;
      err_o   <= err_i;
      if (load_i) data_o <= data_i;
    end
  end

  assert_valid_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_hold_between_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
endmodule

// File: rtl/tdm_deser.sv
module tdm_deser
  import tdm_deser_pkg::*;
#(
  parameter int unsigned NUM_CH    = 8,
  parameter int unsigned SAMPLE_W  = 24,
  parameter int unsigned SLOT_W    = 32,
  parameter int unsigned NUM_LINES = 2,
  localparam int unsigned FRAME_BITS = NUM_CH * SLOT_W,
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS),
  localparam int unsigned OUT_W      = NUM_CH * SAMPLE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dual_mode_i,
  input  logic                 fsync_i,
  input  logic [NUM_LINES-1:0] sdata_i,
  output logic [OUT_W-1:0]     samples_o,
  output logic                 frame_valid_o,
  output logic                 frame_err_o
);
  frame_mode_e      mode;
  logic             cap_en;
  logic [CNT_W-1:0] bit_idx;
  logic             done;
  logic             err;
  logic [OUT_W-1:0] shifted;

  assign mode = dual_mode_i ? FRAME_DUAL : FRAME_OCTAL;

  tdm_frame_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk_i, .rst_ni, .mode_i(mode), .fsync_i,
    .cap_en_o(cap_en), .bit_idx_o(bit_idx), .done_o(done), .err_o(err)
  );

  tdm_slot_capture #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .NUM_LINES(NUM_LINES)
  ) u_cap (
    .clk_i, .rst_ni, .mode_i(mode), .cap_en_i(cap_en), .bit_idx_i(bit_idx),
    .sdata_i, .shift_o(shifted)
  );

  tdm_out_reg #(.WIDTH(OUT_W)) u_out (
    .clk_i, .rst_ni, .load_i(done), .err_i(err), .data_i(shifted),
    .data_o(samples_o), .valid_o(frame_valid_o), .err_o(frame_err_o)
  );

  assert_err_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o);
  assert_err_no_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> (!frame_valid_o && $stable(samples_o)));
endmodule

// File: tb/tdm_deser_test.sv
`timescale 1ns/1ps
module tdm_deser_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         dual = 1'b0;
  logic         fsync = 1'b0;
  logic [1:0]   sdata = '0;
  logic [191:0] samples;
  logic         valid, err;

  int n_run = 0, n_fail = 0, vcount = 0, frames = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) if (valid) vcount++;

  tdm_deser uut (
    .clk_i(clk), .rst_ni(rst_ni), .dual_mode_i(dual), .fsync_i(fsync),
    .sdata_i(sdata), .samples_o(samples), .frame_valid_o(valid), .frame_err_o(err)
  );

  // {dual, ch7 .. ch0}
  localparam logic [192:0] VEC [4] = '{
    {1'b0, 24'hAAAAAA, 24'h555555, 24'hABCDEF, 24'h123456, 24'hFFFFFF, 24'h000001, 24'h7FFFFF, 24'h800000},
    {1'b1, 24'h010203, 24'hFEDCBA, 24'h2468AC, 24'h13579B, 24'h800001, 24'h000000, 24'hF0F0F0, 24'h0F0F0F},
    {1'b0, 24'h888888, 24'h777777, 24'h666666, 24'h555555, 24'h444444, 24'h333333, 24'h222222, 24'h111111},
    {1'b1, 24'hBFFFFF, 24'h400000, 24'hFF00FF, 24'h00FF00, 24'h89ABCD, 24'h765432, 24'h3FFFFF, 24'hC00000}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [191:0] act, input logic [191:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic drv_bit(input logic [191:0] s, input logic d, input int line, input int j);
    int slot = j / 32;
    int pos  = j % 32;
    int ch;
    if (pos >= 24) return ((j * 5 + line) % 3) == 0;   // pad noise
    if (d) ch = (line == 0) ? slot : 4 + slot;
    else begin
      if (line != 0) return (j % 3) == 1;                 // unused line noise
      ch = slot;
    end
    return s[ch*24 + 23 - pos];
  endfunction

  // stop_at < frame length aborts early; fs_len = sync high bits
  task automatic send_frame(input logic d, input logic [191:0] s, input int stop_at,
                            input bit exp_err, input logic [191:0] prev, input int fs_len);
    int fl = d ? 128 : 256;
    int n  = (stop_at < fl) ? stop_at : fl;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (j == 1) begin
        check(err == exp_err, "R7", "error strobe", {191'b0, err}, {191'b0, exp_err});
        check(samples === prev, "R6", "samples held during frame", samples, prev);
      end
      dual  = d;
      fsync = (j < fs_len);
      sdata = {drv_bit(s, d, 1, j), drv_bit(s, d, 0, j)};
    end
    if (n == fl) begin
      @(posedge clk); #1;
      check(valid == 1'b1, "R6", "valid after last bit", {191'b0, valid}, 192'd1);
      if (d) check(samples === s, "R4", "dual frame samples", samples, s);
      else   check(samples === s, "R3", "octal frame samples", samples, s);
      frames++;
      @(posedge clk); #1;
      check(valid == 1'b0, "R6", "valid single cycle", {191'b0, valid}, 192'd0);
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [191:0] prev = '0;
    // R1 reset state, with activity on inputs
    repeat (3) begin
      @(negedge clk);
      fsync = ~fsync;
      sdata = ~sdata;
    end
    @(negedge clk);
    check(samples === '0, "R1", "samples in reset", samples, '0);
    check(valid == 0 && err == 0, "R1", "strobes in reset", {190'b0, valid, err}, '0);
    fsync = 0;
    rst_ni = 1;
    repeat (4) @(negedge clk);

    // table walk: R3 R4 R5 (pad and unused-line noise)
    for (int i = 0; i < 4; i++) begin
      send_frame(VEC[i][192], VEC[i][191:0], 999, 1'b0, prev, 3);
      prev = VEC[i][191:0];
    end

    // R7: octal frame cut at bit 100, then a full octal frame
    send_frame(1'b0, VEC[3][191:0], 100, 1'b0, prev, 3);
    send_frame(1'b0, VEC[1][191:0], 999, 1'b1, prev, 3);
    prev = VEC[1][191:0];

    // R7 boundary: dual frame cut at its last bit
    send_frame(1'b1, VEC[0][191:0], 127, 1'b0, prev, 3);
    send_frame(1'b1, VEC[2][191:0], 999, 1'b1, prev, 3);
    prev = VEC[2][191:0];

    // R2: long sync high does not restart the frame
    send_frame(1'b1, VEC[3][191:0], 999, 1'b0, prev, 40);
    prev = VEC[3][191:0];
    send_frame(1'b0, VEC[0][191:0], 999, 1'b0, prev, 200);
    prev = VEC[0][191:0];

    // R8: idle with data toggling, no sync edge
    for (int j = 0; j < 300; j++) begin
      @(negedge clk);
      fsync = 0;
      sdata = 2'(j);
    end
    @(negedge clk);
    check(vcount == frames, "R8", "valid count matches full frames",
          192'(vcount), 192'(frames));
    check(samples === prev, "R8", "samples unchanged while idle", samples, prev);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule